// File: doc/BRIEF.md
# Parameter-Filtered Binary Content-Addressable Memory

This block is a small binary content-addressable memory. Next to each stored data word it keeps a short parameter word and a valid bit. A gate-tree extractor computes the parameter from the data. Every 8-bit group of the word is folded into a single parameter bit by a fixed tree of three gate levels. Each node of the tree is a NAND, NOR or XOR gate, and the choice is set per node at elaboration time.

A write stores the data word and its parameter together and marks the entry valid. On a search the same extractor reduces the key. Only entries that are valid and whose stored parameter equals the key's parameter become candidates, and only candidates go on to the full data comparison. The block returns the candidate vector, the per-entry match vector, a hit flag and the lowest matching index, all registered one cycle after the search is presented. An invalidate port clears the valid bit of a single entry.

Top module: `pbcam_top`

## Requirements
- R1: While `rst` is high on a clock edge, every entry becomes invalid. After that edge `res_vld`, `hit`, `hit_addr`, `cand_vec` and `match_vec` are all zero.
- R2: The parameter has DATA_W/8 bits. Bit g comes from data bits 8g..8g+7 through seven nodes, and node n of group g takes its 2-bit select from GATE_SEL[14g+2n +: 2]. The codes are 00 NAND, 01 NOR and 10 XOR; code 11 acts as XOR. Nodes 0..3 combine the bit pairs (8g,8g+1), (8g+2,8g+3), (8g+4,8g+5) and (8g+6,8g+7). Node 4 combines nodes 0 and 1, node 5 combines nodes 2 and 3, and node 6 combines nodes 4 and 5 to give bit g.
- R3: A write stores the data and its parameter and sets valid on the clock edge where `wr_en` is sampled. A search on the next edge sees the new entry. A search on the same edge as the write sees the old contents.
- R4: An `inv_en` on an edge clears the valid bit of `inv_addr`, and an invalid entry never shows up in `cand_vec` or `match_vec`. If a write and an invalidate target the same entry on the same edge, the write wins and the entry is valid.
- R5: Bit i of `cand_vec` is set exactly when entry i is valid and its stored parameter equals the parameter of `srch_key`.
- R6: Bit i of `match_vec` is set exactly when entry i is a candidate and its stored data equals `srch_key`. A candidate whose data differs from the key never matches.
- R7: `hit` is the OR of `match_vec`. `hit_addr` is the lowest index whose match bit is set, and it is 0 when there is no hit.
- R8: All results are registered on the edge that samples `srch_en`, so they appear one cycle after the search is presented. An edge with `srch_en` low clears `res_vld`, `hit`, `hit_addr`, `cand_vec` and `match_vec`.
- R9: Writing an entry that is already valid replaces its data. A key equal to the old data no longer hits at that index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Entry to write |
| wr_data | input | DATA_W | Data word to store |
| inv_en | input | 1 | Invalidate strobe |
| inv_addr | input | AW | Entry to invalidate |
| srch_en | input | 1 | Search strobe |
| srch_key | input | DATA_W | Search key |
| res_vld | output | 1 | Registered result belongs to a search |
| cand_vec | output | DEPTH | Entries that passed the parameter pre-filter |
| match_vec | output | DEPTH | Entries that fully match the key |
| hit | output | 1 | At least one entry matched |
| hit_addr | output | AW | Lowest matching index |

## Verification
The bound checker verifies on every cycle the relations among the registered results. These are that matches are a subset of candidates, that the hit flag agrees with the match vector, that the reported index is the lowest set bit (and zero on a miss), that idle cycles clear everything, and that reset leaves the outputs zero. Only the bench scenarios can show that the right entries are marked: that the parameter tree follows the node and code order, the timing of a write against a search in the same cycle and the next cycle, that an invalidate loses to a write, that overwritten data stops matching, and that a key sharing an entry's parameter but not its data is filtered only by the full comparison. A random sweep also compares the number of candidates with the number of valid entries to show that the pre-filter reduces the work.

// File: rtl/pbcam_pkg.sv
package pbcam_pkg;

  typedef enum logic [1:0] {
    GT_NAND = 2'b00,
    GT_NOR  = 2'b01,
    GT_XOR  = 2'b10,
    GT_XOR2 = 2'b11
  } gate_e;

  localparam int unsigned NODES_PER_GRP = 7;
  localparam int unsigned SEL_PER_GRP   = 2 * NODES_PER_GRP;

  function automatic logic gate_eval(input logic [1:0] sel, input logic a, input logic b);
    logic y;
    case (gate_e'(sel))
      GT_NAND: y = ~(a & b);
      GT_NOR:  y = ~(a | b);
      default: y = a ^ b;
    endcase
    return y;
  endfunction

endpackage

// File: rtl/pbcam_extract.sv
module pbcam_extract
  import pbcam_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NG    = DATA_W / 8,
  parameter logic [SEL_PER_GRP*NG-1:0] GATE_SEL = {NG{14'b10_10_10_01_00_01_00}}
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [NG-1:0]     param_o
);

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic [3:0] lvl1;
    logic [1:0] lvl2;
    for (genvar n = 0; n < 4; n++) begin : g_l1
      assign lvl1[n] = gate_eval(GATE_SEL[g*SEL_PER_GRP + 2*n +: 2],
                                 data_i[8*g + 2*n], data_i[8*g + 2*n + 1]);
    end
    for (genvar n = 0; n < 2; n++) begin : g_l2
      assign lvl2[n] = gate_eval(GATE_SEL[g*SEL_PER_GRP + 8 + 2*n +: 2],
                                 lvl1[2*n], lvl1[2*n + 1]);
    end
    assign param_o[g] = gate_eval(GATE_SEL[g*SEL_PER_GRP + 12 +: 2], lvl2[0], lvl2[1]);
  end

endmodule

// File: rtl/pbcam_store.sv
module pbcam_store #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PW     = DATA_W / 8,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [AW-1:0]                 wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [PW-1:0]                 wr_param,
  input  logic                          inv_en,
  input  logic [AW-1:0]                 inv_addr,
  output logic [DEPTH-1:0]              valid_o,
  output logic [DEPTH-1:0][DATA_W-1:0]  data_o,
  output logic [DEPTH-1:0][PW-1:0]      param_o
);

  logic [DEPTH-1:0][DATA_W-1:0] data_mem;
  logic [DEPTH-1:0][PW-1:0]     par_mem;
  logic [DEPTH-1:0]             valid_q;

  // Payload arrays carry no reset; only the valid bits do.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      data_mem[wr_addr] <= wr_data;
      par_mem[wr_addr]  <= wr_param;
    end
  end

  // Invalidate first, write last: a write to the same entry wins.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      if (inv_en) valid_q[inv_addr] <= 1'b0;
      if (wr_en)  valid_q[wr_addr]  <= 1'b1;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_mem;
  assign param_o = par_mem;

endmodule

// File: rtl/pbcam_match.sv
module pbcam_match #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PW     = DATA_W / 8
) (
  input  logic                          en,
  input  logic [DEPTH-1:0]              valid_i,
  input  logic [DEPTH-1:0][DATA_W-1:0]  data_i,
  input  logic [DEPTH-1:0][PW-1:0]      param_i,
  input  logic [DATA_W-1:0]             key_i,
  input  logic [PW-1:0]                 key_param_i,
  output logic [DEPTH-1:0]              cand_o,
  output logic [DEPTH-1:0]              match_o
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign cand_o[i]  = en && valid_i[i] && (param_i[i] == key_param_i);
    assign match_o[i] = cand_o[i] && (data_i[i] == key_i);
  end

endmodule

// File: rtl/pbcam_prienc.sv
module pbcam_prienc #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] req_i,
  output logic             any_o,
  output logic [AW-1:0]    idx_o
);

  always_comb begin
    idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = AW'(i);
    end
  end

  assign any_o = |req_i;

endmodule

// File: rtl/pbcam_top.sv
module pbcam_top
  import pbcam_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned NG    = DATA_W / 8,
  localparam int unsigned AW    = $clog2(DEPTH),
  parameter logic [SEL_PER_GRP*NG-1:0] GATE_SEL = {NG{14'b10_10_10_01_00_01_00}}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              inv_en,
  input  logic [AW-1:0]     inv_addr,
  input  logic              srch_en,
  input  logic [DATA_W-1:0] srch_key,
  output logic              res_vld,
  output logic [DEPTH-1:0]  cand_vec,
  output logic [DEPTH-1:0]  match_vec,
  output logic              hit,
  output logic [AW-1:0]     hit_addr
);

  logic [NG-1:0]                wr_param;
  logic [NG-1:0]                key_param;
  logic [DEPTH-1:0]             ent_valid;
  logic [DEPTH-1:0][DATA_W-1:0] ent_data;
  logic [DEPTH-1:0][NG-1:0]     ent_param;
  logic [DEPTH-1:0]             cand_c;
  logic [DEPTH-1:0]             match_c;
  logic                         any_c;
  logic [AW-1:0]                idx_c;

  pbcam_extract #(.DATA_W(DATA_W), .GATE_SEL(GATE_SEL)) u_ext_wr (
    .data_i (wr_data),
    .param_o(wr_param)
  );

  pbcam_extract #(.DATA_W(DATA_W), .GATE_SEL(GATE_SEL)) u_ext_key (
    .data_i (srch_key),
    .param_o(key_param)
  );

  pbcam_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PW(NG)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wr_param(wr_param),
    .inv_en  (inv_en),
    .inv_addr(inv_addr),
    .valid_o (ent_valid),
    .data_o  (ent_data),
    .param_o (ent_param)
  );

  pbcam_match #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PW(NG)) u_match (
    .en         (srch_en),
    .valid_i    (ent_valid),
    .data_i     (ent_data),
    .param_i    (ent_param),
    .key_i      (srch_key),
    .key_param_i(key_param),
    .cand_o     (cand_c),
    .match_o    (match_c)
  );

  pbcam_prienc #(.DEPTH(DEPTH)) u_enc (
    .req_i(match_c),
    .any_o(any_c),
    .idx_o(idx_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld   <= 1'b0;
      cand_vec  <= '0;
      match_vec <= '0;
      hit       <= 1'b0;
      hit_addr  <= '0;
    end else begin
      res_vld   <= srch_en;
      cand_vec  <= cand_c;
      match_vec <= match_c;
      hit       <= any_c;
      hit_addr  <= idx_c;
    end
  end

endmodule

// File: rtl/pbcam_chk.sv
module pbcam_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             srch_en,
  input logic             res_vld,
  input logic [DEPTH-1:0] cand_vec,
  input logic [DEPTH-1:0] match_vec,
  input logic             hit,
  input logic [AW-1:0]    hit_addr
);

  logic             rst_d;
  logic [DEPTH-1:0] below_mask;

  always_ff @(posedge clk) rst_d <= rst;

  assign below_mask = ({{(DEPTH-1){1'b0}}, 1'b1} << hit_addr) - 1'b1;

  always @(posedge clk) begin
    if (rst_d === 1'b1) begin
      assert_reset_clear_R1: assert (!res_vld && !hit && hit_addr == '0 &&
                                     cand_vec == '0 && match_vec == '0);
    end
  end

  assert_match_in_cand_R6: assert property (@(posedge clk) disable iff (rst)
    (match_vec & ~cand_vec) == '0);

  assert_hit_is_or_R7: assert property (@(posedge clk) disable iff (rst)
    hit == (|match_vec));

  assert_lowest_index_R7: assert property (@(posedge clk) disable iff (rst)
    hit |-> (match_vec[hit_addr] && (match_vec & below_mask) == '0));

  assert_miss_addr_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !hit |-> hit_addr == '0);

  assert_idle_clears_R8: assert property (@(posedge clk) disable iff (rst)
    !srch_en |=> (!res_vld && !hit && cand_vec == '0 && match_vec == '0));

endmodule

bind pbcam_top pbcam_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .srch_en  (srch_en),
  .res_vld  (res_vld),
  .cand_vec (cand_vec),
  .match_vec(match_vec),
  .hit      (hit),
  .hit_addr (hit_addr)
);

// File: tb/sim_pbcam_top.sv
module sim_pbcam_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW    = 32;
  localparam int DEP   = 16;
  localparam int AWB   = 4;
  localparam int NGR   = DW / 8;
  localparam logic [14*NGR-1:0] GSEL = {NGR{14'b10_10_10_01_00_01_00}};

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_en = 1'b0;
  logic [AWB-1:0]  wr_addr = '0;
  logic [DW-1:0]   wr_data = '0;
  logic            inv_en = 1'b0;
  logic [AWB-1:0]  inv_addr = '0;
  logic            srch_en = 1'b0;
  logic [DW-1:0]   srch_key = '0;
  logic            res_vld;
  logic [DEP-1:0]  cand_vec;
  logic [DEP-1:0]  match_vec;
  logic            hit;
  logic [AWB-1:0]  hit_addr;

  int n_chk = 0;
  int n_bad = 0;
  int tot_cand = 0;
  int tot_valid = 0;
  bit finished = 0;

  logic [DW-1:0] m_data [DEP];
  logic          m_val  [DEP];

  always #(CLK_PERIOD/2) clk = ~clk;

  pbcam_top #(.DATA_W(DW), .DEPTH(DEP), .GATE_SEL(GSEL)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .inv_en(inv_en), .inv_addr(inv_addr), .srch_en(srch_en), .srch_key(srch_key),
    .res_vld(res_vld), .cand_vec(cand_vec), .match_vec(match_vec), .hit(hit),
    .hit_addr(hit_addr)
  );

  function automatic logic g_op(input logic [1:0] s, input logic a, input logic b);
    if (s == 2'b00) return !(a && b);
    if (s == 2'b01) return !(a || b);
    return a != b;
  endfunction

  // R2 model: per group, four pair nodes, two middle nodes, one root.
  function automatic logic [NGR-1:0] ref_param(input logic [DW-1:0] d);
    logic [NGR-1:0] p;
    for (int g = 0; g < NGR; g++) begin
      logic [13:0] s;
      logic a0, a1, a2, a3, b0, b1;
      s  = GSEL[g*14 +: 14];
      a0 = g_op(s[1:0], d[8*g+0], d[8*g+1]);
      a1 = g_op(s[3:2], d[8*g+2], d[8*g+3]);
      a2 = g_op(s[5:4], d[8*g+4], d[8*g+5]);
      a3 = g_op(s[7:6], d[8*g+6], d[8*g+7]);
      b0 = g_op(s[9:8], a0, a1);
      b1 = g_op(s[11:10], a2, a3);
      p[g] = g_op(s[13:12], b0, b1);
    end
    return p;
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, let the rising edge act, check at the next fall.
  task automatic step(input logic w, input logic [AWB-1:0] wa, input logic [DW-1:0] wd,
                      input logic iv, input logic [AWB-1:0] ia,
                      input logic se, input logic [DW-1:0] k, input string req);
    logic [DEP-1:0] ec, em;
    logic [AWB-1:0] ea;
    logic eh;
    ec = '0; em = '0; ea = '0; eh = 1'b0;
    for (int i = 0; i < DEP; i++) begin
      ec[i] = se && m_val[i] && (ref_param(m_data[i]) == ref_param(k));
      em[i] = ec[i] && (m_data[i] == k);
    end
    for (int i = DEP - 1; i >= 0; i--) if (em[i]) ea = AWB'(i);
    eh = |em;
    if (se) begin
      for (int i = 0; i < DEP; i++) if (m_val[i]) tot_valid++;
      for (int i = 0; i < DEP; i++) if (ec[i]) tot_cand++;
    end
    wr_en = w; wr_addr = wa; wr_data = wd;
    inv_en = iv; inv_addr = ia; srch_en = se; srch_key = k;
    @(posedge clk);
    if (iv) m_val[ia] = 1'b0;
    if (w) begin m_data[wa] = wd; m_val[wa] = 1'b1; end
    @(negedge clk);
    wr_en = 1'b0; inv_en = 1'b0; srch_en = 1'b0;
    check(req, "res_vld", 64'(res_vld), 64'(se));
    check(req, "cand_vec", 64'(cand_vec), 64'(ec));
    check(req, "match_vec", 64'(match_vec), 64'(em));
    check(req, "hit", 64'(hit), 64'(eh));
    check(req, "hit_addr", 64'(hit_addr), 64'(ea));
  endtask

  task automatic do_write(input logic [AWB-1:0] a, input logic [DW-1:0] d, input string req);
    step(1'b1, a, d, 1'b0, '0, 1'b0, '0, req);
  endtask

  task automatic do_search(input logic [DW-1:0] k, input string req);
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, k, req);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    for (int i = 0; i < DEP; i++) begin m_val[i] = 1'b0; m_data[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", "res_vld", 64'(res_vld), 64'd0);
    check("R1", "hit", 64'(hit), 64'd0);
    check("R1", "match_vec", 64'(match_vec), 64'd0);
    check("R1", "cand_vec", 64'(cand_vec), 64'd0);
    do_search(32'h0000_0000, "R1");
    do_search(32'hFFFF_FFFF, "R1");
  endtask

  task automatic t_fill_and_find;
    for (int i = 0; i < DEP; i++) do_write(AWB'(i), 32'hA5000000 ^ (i * 32'h01030507), "R3");
    for (int i = 0; i < DEP; i++) do_search(32'hA5000000 ^ (i * 32'h01030507), "R6");
    do_search(32'h1234_5678, "R6");
  endtask

  task automatic t_duplicate;
    do_write(4'd9, 32'hCAFE_0001, "R7");
    do_write(4'd3, 32'hCAFE_0001, "R7");
    do_search(32'hCAFE_0001, "R7");
    check("R7", "lowest index", 64'(hit_addr), 64'd3);
  endtask

  task automatic t_param_alias;
    logic [DW-1:0] base, other;
    int tries;
    base = m_data[5];
    other = base;
    tries = 0;
    while ((other == base || ref_param(other) != ref_param(base)) && tries < 2000) begin
      other = $urandom;
      tries++;
    end
    do_search(other, "R5");
    check("R5", "alias candidate bit", 64'(cand_vec[5]), 64'd1);
    check("R6", "alias no match", 64'(match_vec[5]), 64'd0);
    other = base ^ 32'h0000_0001;
    do_search(other, "R2");
  endtask

  task automatic t_invalidate;
    logic [DW-1:0] d;
    d = m_data[7];
    step(1'b0, '0, '0, 1'b1, 4'd7, 1'b0, '0, "R4");
    do_search(d, "R4");
    check("R4", "invalid entry cand", 64'(cand_vec[7]), 64'd0);
    step(1'b1, 4'd7, d, 1'b1, 4'd7, 1'b0, '0, "R4");
    do_search(d, "R4");
    check("R4", "write beats invalidate", 64'(match_vec[7]), 64'd1);
  endtask

  task automatic t_same_cycle;
    step(1'b1, 4'd12, 32'h0BAD_F00D, 1'b0, '0, 1'b1, 32'h0BAD_F00D, "R3");
    check("R3", "same-cycle miss", 64'(hit), 64'd0);
    do_search(32'h0BAD_F00D, "R3");
    check("R3", "next-cycle hit", 64'(hit), 64'd1);
  endtask

  task automatic t_overwrite;
    logic [DW-1:0] old;
    old = m_data[14];
    do_write(4'd14, 32'h7777_0E0E, "R9");
    do_search(old, "R9");
    check("R9", "old data bit", 64'(match_vec[14]), 64'd0);
    do_search(32'h7777_0E0E, "R9");
  endtask

  task automatic t_idle;
    do_search(m_data[0], "R8");
    step(1'b0, '0, '0, 1'b0, '0, 1'b0, m_data[0], "R8");
  endtask

  task automatic t_random;
    tot_cand = 0; tot_valid = 0;
    for (int n = 0; n < 300; n++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 2) do_write(AWB'($urandom_range(0, DEP-1)), $urandom, "R3");
      else if (r < 3) step(1'b0, '0, '0, 1'b1, AWB'($urandom_range(0, DEP-1)), 1'b0, '0, "R4");
      else if (r < 6) do_search(m_data[$urandom_range(0, DEP-1)], "R6");
      else do_search($urandom, "R5");
    end
    $display("pre-filter: %0d candidates out of %0d valid entry compares", tot_cand, tot_valid);
    check("R5", "pre-filter reduces compares", 64'(tot_cand < tot_valid), 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_fill_and_find();
    t_duplicate();
    t_param_alias();
    t_invalidate();
    t_same_cycle();
    t_overwrite();
    t_idle();
    t_random();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule